// File: doc/BRIEF.md
# Refresh-Slot Framebuffer Fetcher

This block streams display bytes from main memory by borrowing the processor's DRAM refresh slots. The processor never waits. Each instruction fetch is followed by a refresh cycle. While that cycle lasts, the block drives the physical address bus with a framebuffer location. The location is built from a programmable base, a few extension counter bits and the processor's own 7-bit refresh address. The normal page-mapper output is overridden for that time, so the framebuffer can sit in a page that software normally keeps unmapped.

The processor's refresh address counts through 128 values. Each time it rolls over from 127 to 0, a small extension counter advances. With the default three extension bits, this gives a 10-bit byte index that covers a 1 KB frame. Software only writes the base. At the end of each refresh cycle the returned byte is handed to the display side with a one-cycle valid strobe. A frame-start marker goes with the byte at index zero.

Bytes arrive at a rate set by the instruction mix, not at a fixed pace. The display side must accept a byte whenever the valid strobe appears.

Top module: `rfsh_fb_fetcher`

## Requirements
- R1: After reset the frame base is 0, the extension bits are 0, and both pix_valid and frame_start are low.
- R2: While rfsh is high, phys_addr equals {base, extension bits, rf_addr} and map_bypass is high.
- R3: While rfsh is low, phys_addr equals cpu_paddr and map_bypass is low.
- R4: A wrap is a refresh cycle that begins (rfsh rising) with rf_addr = 0 when the previous refresh cycle carried rf_addr = 127. On a wrap, the extension bits increase by one, and the new value is already used in that cycle's address. No other refresh start changes them.
- R5: The extension bits count modulo 2^EXT_W. After 1024 consecutive sequential refresh addresses (default EXT_W = 3), the byte index returns to 0.
- R6: pix_data takes the value of mem_rdata sampled on the last clock edge at which rfsh was high. pix_valid is high for exactly one cycle, starting one clock after the first edge that samples rfsh low.
- R7: frame_start is high together with pix_valid exactly when the index {extension bits, rf_addr} of the delivered byte was 0.
- R8: An I/O write to port 8'h40 loads base[7:0] from io_wdata. A write to port 8'h41 loads base[11:8] from io_wdata[3:0]. A write to any other port leaves the base unchanged.
- R9: mem_rdata outside refresh cycles has no effect: pix_valid never rises without a preceding refresh cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfsh | input | 1 | High during a processor refresh cycle |
| rf_addr | input | 7 | Processor refresh address |
| cpu_paddr | input | 22 | Physical address from the page mappers |
| mem_rdata | input | 8 | Memory read data |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| phys_addr | output | 22 | Physical address to memory |
| map_bypass | output | 1 | High when the mapper output is overridden |
| pix_data | output | 8 | Fetched framebuffer byte |
| pix_valid | output | 1 | One-cycle strobe for pix_data |
| frame_start | output | 1 | Marks the byte at index 0 |

## Verification
The fetcher is tested with refresh strobes one and two cycles long, separated by gaps of different lengths. These patterns separate capture of the last sampled byte from capture of the first one, and confirm that the valid pulse follows the strobe's fall, not its rise. A run of more than 1024 sequential refresh addresses crosses every extension carry and two frame starts. A deliberate jump from 50 to 0 shows that only a true 127-to-0 step is treated as a wrap. The base is rewritten in the middle of the run. Writes to an unrelated port and bus data seen outside refresh cycles show that neither the base nor the output strobe reacts to them.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  localparam int LO_W = 7;
  localparam logic [LO_W-1:0] LO_TOP = '1;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/fbf_base_reg.sv
module fbf_base_reg #(
  parameter int BASE_W = 12,
  parameter logic [7:0] PORT_LO = 8'h40,
  parameter logic [7:0] PORT_HI = 8'h41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [7:0]        io_port,
  input  logic [7:0]        io_wdata,
  output logic [BASE_W-1:0] base
);
  logic [BASE_W-1:0] base_q, base_d;

  generate
    if (BASE_W > 8) begin : g_two_ports
      always_comb begin
        base_d = base_q;
        if (io_wr && io_port == PORT_LO) base_d[7:0] = io_wdata;
        if (io_wr && io_port == PORT_HI) base_d[BASE_W-1:8] = io_wdata[BASE_W-9:0];
      end
    end else begin : g_one_port
      always_comb begin
        base_d = base_q;
        if (io_wr && io_port == PORT_LO) base_d = io_wdata[BASE_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  assign base = base_q;

  // R8
  base_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(base_q) |-> $past(io_wr));
endmodule

// File: rtl/fbf_index.sv
module fbf_index
  import fbf_pkg::*;
#(
  parameter int EXT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rfsh,
  input  logic [LO_W-1:0]  rf_addr,
  output logic [EXT_W-1:0] ext_now
);
  logic             rfsh_q;
  logic [LO_W-1:0]  prev_q, prev_d;
  logic [EXT_W-1:0] ext_q, ext_d;
  logic             wrap;

  always_comb begin
    wrap    = rfsh && !rfsh_q && (rf_addr == '0) && (prev_q == LO_TOP);
    ext_d   = wrap ? ext_q + EXT_W'(1) : ext_q;
    prev_d  = rfsh ? rf_addr : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rfsh_q <= 1'b0;
      prev_q <= '0;
      ext_q  <= '0;
    end else begin
      rfsh_q <= rfsh;
      prev_q <= prev_d;
      ext_q  <= ext_d;
    end
  end

  assign ext_now = ext_d;

  // R4
  ext_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ext_q) |-> ext_q == EXT_W'($past(ext_q) + EXT_W'(1)));
endmodule

// File: rtl/fbf_capture.sv
module fbf_capture
  import fbf_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rfsh,
  input  logic [IDX_W-1:0] idx,
  input  byte_t            mem_rdata,
  output byte_t            pix_data,
  output logic             pix_valid,
  output logic             frame_start
);
  logic  rfsh_q, zero_q, zero_d, valid_q, valid_d, fs_q, fs_d, done;
  byte_t hold_q, hold_d, data_q, data_d;

  always_comb begin
    done    = rfsh_q && !rfsh;
    hold_d  = rfsh ? mem_rdata : hold_q;
    zero_d  = rfsh ? (idx == '0) : zero_q;
    valid_d = done;
    data_d  = done ? hold_q : data_q;
    fs_d    = done && zero_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rfsh_q  <= 1'b0;
      hold_q  <= '0;
      zero_q  <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      fs_q    <= 1'b0;
    end else begin
      rfsh_q  <= rfsh;
      hold_q  <= hold_d;
      zero_q  <= zero_d;
      valid_q <= valid_d;
      data_q  <= data_d;
      fs_q    <= fs_d;
    end
  end

  assign pix_data    = data_q;
  assign pix_valid   = valid_q;
  assign frame_start = fs_q;

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);
endmodule

// File: rtl/rfsh_fb_fetcher.sv
module rfsh_fb_fetcher
  import fbf_pkg::*;
#(
  parameter int PHYS_W = 22,
  parameter int EXT_W = 3,
  parameter logic [7:0] PORT_LO = 8'h40,
  parameter logic [7:0] PORT_HI = 8'h41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rfsh,
  input  logic [6:0]        rf_addr,
  input  logic [PHYS_W-1:0] cpu_paddr,
  input  logic [7:0]        mem_rdata,
  input  logic              io_wr,
  input  logic [7:0]        io_port,
  input  logic [7:0]        io_wdata,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              map_bypass,
  output logic [7:0]        pix_data,
  output logic              pix_valid,
  output logic              frame_start
);
  localparam int IDX_W  = LO_W + EXT_W;
  localparam int BASE_W = PHYS_W - IDX_W;

  logic [1:0]        rst_sync;
  logic              rst_i;
  logic [BASE_W-1:0] base;
  logic [EXT_W-1:0]  ext_now;
  logic [IDX_W-1:0]  idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  fbf_base_reg #(.BASE_W(BASE_W), .PORT_LO(PORT_LO), .PORT_HI(PORT_HI)) u_base (
    .clk(clk), .rst_n(rst_i), .io_wr(io_wr), .io_port(io_port),
    .io_wdata(io_wdata), .base(base));

  fbf_index #(.EXT_W(EXT_W)) u_index (
    .clk(clk), .rst_n(rst_i), .rfsh(rfsh), .rf_addr(rf_addr), .ext_now(ext_now));

  assign idx = {ext_now, rf_addr};

  fbf_capture #(.IDX_W(IDX_W)) u_cap (
    .clk(clk), .rst_n(rst_i), .rfsh(rfsh), .idx(idx), .mem_rdata(mem_rdata),
    .pix_data(pix_data), .pix_valid(pix_valid), .frame_start(frame_start));

  always_comb begin
    map_bypass = rfsh;
    phys_addr  = rfsh ? {base, idx} : cpu_paddr;
  end

  // R7
  fs_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_i)
    frame_start |-> pix_valid);
  // R9
  valid_after_rfsh_chk: assert property (@(posedge clk) disable iff (!rst_i)
    pix_valid |-> ($past(rfsh, 2) && !$past(rfsh)));
endmodule

// File: tb/rfsh_fb_fetcher_test.sv
module rfsh_fb_fetcher_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rfsh;
  logic [6:0]  rf_addr;
  logic [21:0] cpu_paddr;
  logic [7:0]  mem_rdata;
  logic        io_wr;
  logic [7:0]  io_port, io_wdata;
  logic [21:0] phys_addr;
  logic        map_bypass;
  logic [7:0]  pix_data;
  logic        pix_valid, frame_start;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_base = 0, m_ext = 0, m_prev = 0, m_hold = 0, m_hidx = 0;
  bit m_rprev = 0, m_valid = 0, m_fs = 0;
  int m_data = 0, m_frames = 0;

  always #(CLK_NS/2) clk = ~clk;

  rfsh_fb_fetcher uut (
    .clk(clk), .rst_n(rst_n), .rfsh(rfsh), .rf_addr(rf_addr), .cpu_paddr(cpu_paddr),
    .mem_rdata(mem_rdata), .io_wr(io_wr), .io_port(io_port), .io_wdata(io_wdata),
    .phys_addr(phys_addr), .map_bypass(map_bypass), .pix_data(pix_data),
    .pix_valid(pix_valid), .frame_start(frame_start));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic cyc(input bit r, input int a, input int c, input int d,
                     input bit w, input int p, input int wd);
    int ext_eff, exp_pa;
    @(negedge clk);
    chk(m_rprev ? "R6" : "R9", pix_valid, m_valid);
    chk(m_frames > 1 ? "R5" : "R7", frame_start, m_fs);
    if (m_valid) chk("R6", pix_data, m_data);
    rfsh = r; rf_addr = 7'(a); cpu_paddr = 22'(c); mem_rdata = 8'(d);
    io_wr = w; io_port = 8'(p); io_wdata = 8'(wd);
    ext_eff = m_ext;
    if (r && !m_rprev && a == 0 && m_prev == 127) ext_eff = (m_ext + 1) % 8;
    exp_pa = r ? (m_base * 1024 + ext_eff * 128 + a) : c;
    #1;
    chk(r ? (ext_eff != 0 ? "R4" : "R2") : "R3", phys_addr, exp_pa);
    chk(r ? "R2" : "R3", map_bypass, r);
    @(posedge clk);
    m_valid = m_rprev && !r;
    m_fs = m_valid && (m_hidx == 0);
    if (m_fs) m_frames++;
    if (m_valid) m_data = m_hold;
    if (r) begin
      m_hold = d; m_hidx = ext_eff * 128 + a; m_prev = a; m_ext = ext_eff;
    end
    if (w && p == 'h40) m_base = (m_base & 'hF00) | wd;
    if (w && p == 'h41) m_base = (m_base & 'h0FF) | ((wd & 'hF) << 8);
    m_rprev = r;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 'h12345 + i * 'h111, 'hC3 ^ i, 0, 0, 0);
  endtask

  task automatic fetch(input int a, input int len, input int d);
    for (int k = 0; k < len; k++) cyc(1, a, 0, (d + k * 'h5B) & 'hFF, 0, 0, 0);
    cyc(0, 0, 'h2AAAA, 'h99, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rfsh = 0; rf_addr = 0; cpu_paddr = 0; mem_rdata = 0;
    io_wr = 0; io_port = 0; io_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1", pix_valid, 0);
    chk("R1", frame_start, 0);
    rst_n = 1'b1;
    idle(5);
    // R1: base and extension bits are zero on the first refresh
    fetch(0, 1, 'h11);
    // R8: base written in two halves, plus a stray port
    cyc(0, 0, 0, 0, 1, 'h40, 'h5A);
    cyc(0, 0, 0, 0, 1, 'h41, 'hF3);
    cyc(0, 0, 0, 0, 1, 'h42, 'hFF);
    cyc(1, 1, 0, 'h20, 0, 0, 0);
    chk("R8", phys_addr, 22'h35A * 1024 + 1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    idle(3);
    // R4: a jump to 0 that is not from 127 is not a wrap
    fetch(50, 1, 'h33);
    fetch(0, 2, 'h44);
    // R4 R5 R7: long sequential run with varying strobe length and gap
    for (int i = 0; i < 1100; i++) begin
      fetch(i % 128, 1 + (i % 3 == 0), i * 7 + 3);
      if (i % 2 == 1) idle(1);
      if (i == 600) cyc(0, 0, 0, 0, 1, 'h40, 'hA5);
    end
    chk("R5", m_frames >= 2, 1);
    idle(4);
    finish_run();
  end
endmodule